// File: doc/BRIEF.md
# SHA-384/SHA-512 Block Compression Engine

This block computes one SHA-512 or SHA-384 compression over a single 1024-bit message block. Software writes the block into a bank of thirty-two 32-bit text registers and writes one of four command addresses. The engine then runs the 80 rounds of the 64-bit algorithm and returns the digest through the same registers. Message padding and splitting a message into blocks are left to software.

Every 64-bit word of the algorithm spans two neighbouring text registers. Word `j` is `{reg[2j], reg[2j+1]}`, and the leftmost word of both the block and the digest sits in register 0. A start command begins from the initial hash value of the chosen algorithm. A continue command chains from the full 512-bit state that the previous operation left behind. This is how a long message is hashed one block at a time.

Top module: `sha5_engine`

## Requirements
- R1: After reset all text registers read zero, and `busy` and `done` are low.
- R2: Word addresses 0 to 31 select the text registers. A write while idle stores the data, and a read returns it on `bus_rdata` one clock after the address is presented. Word `j` is `{reg[2j], reg[2j+1]}`.
- R3: A write to address 32 starts SHA-512 and a write to address 34 starts SHA-384. Each command loads its own algorithm's initial hash value and compresses the unpadded block exactly as written.
- R4: When SHA-512 finishes, the digest words 0 to 7 are in registers 0 to 15, and registers 16 to 31 keep their earlier contents.
- R5: When SHA-384 finishes, the digest words 0 to 5 are in registers 0 to 11, and registers 12 to 31 keep their earlier contents.
- R6: A write to address 33 continues SHA-512 and a write to address 35 continues SHA-384. Either one uses the full eight-word state saved from the previous operation as its chaining value.
- R7: `busy` rises one clock after an accepted command. `done` rises, and `busy` falls, 82 clocks after the command edge. `done` clears on the next accepted command. `busy` and `done` are never high together.
- R8: While `busy` is high, writes to the text registers and all commands are ignored.
- R9: A read of address 36 returns a status word with bit 0 = busy and bit 1 = done. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for text registers and commands |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| busy | output | 1 | Compression in progress |
| done | output | 1 | Last operation finished, digest valid |

## Verification
The assertions assume that the host issues at most one access per clock. They also assume that writes during a run go only through the normal port, so any change to a text register while busy outside writeback is a fault. The directed stimulus keeps to this: one write or read per task call, commands with any data value, and deliberate writes and commands while busy to check that they are ignored. Digests are compared against published test vectors for one-block and two-block messages, and the two-block case is what exercises chaining through the continue command.

// File: rtl/sha5_pkg.sv
package sha5_pkg;
  localparam int WORD_W   = 64;
  localparam int HALF_W   = 32;
  localparam int VAR_CNT  = 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [VAR_CNT-1:0][WORD_W-1:0] vars_t;

  // n-th prime, counting from zero (0 -> 2)
  function automatic int nth_prime(input int n);
    int cnt;
    int res;
    cnt = -1;
    res = 0;
    for (int v = 2; v < 1000; v++) begin
      bit isp;
      isp = 1'b1;
      for (int d = 2; d * d <= v; d++)
        if (v % d == 0) isp = 1'b0;
      if (isp && res == 0) begin
        cnt++;
        if (cnt == n) res = v;
      end
    end
    return res;
  endfunction

  // low 64 bits of floor(root(p) * 2^64), root of degree 2 or 3
  function automatic word_t frac_root(input int p, input int deg);
    logic [255:0] x;
    logic [255:0] c;
    logic [255:0] pw;
    logic [71:0]  r;
    x = 256'(p) << (64 * deg);
    r = '0;
    for (int b = 71; b >= 0; b--) begin
      c  = 256'(r | (72'd1 << b));
      pw = (deg == 3) ? c * c * c : c * c;
      if (pw <= x) r = c[71:0];
    end
    return r[63:0];
  endfunction

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction
  function automatic word_t big_s1(input word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction
  function automatic word_t sml_s0(input word_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction
  function automatic word_t sml_s1(input word_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction
endpackage

// File: rtl/sha5_krom.sv
module sha5_krom #(
  parameter int ROUNDS = 80,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic [CNT_W-1:0]    idx,
  output sha5_pkg::word_t     k
);
  sha5_pkg::word_t k_tab [ROUNDS];

  for (genvar t = 0; t < ROUNDS; t++) begin : g_k
    localparam sha5_pkg::word_t KV = sha5_pkg::frac_root(sha5_pkg::nth_prime(t), 3);
    assign k_tab[t] = KV;
  end

  always_comb begin
    k = '0;
    for (int t = 0; t < ROUNDS; t++)
      if (int'(idx) == t) k = k_tab[t];
  end
endmodule

// File: rtl/sha5_sched.sv
module sha5_sched #(
  parameter int NWORDS = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load,
  input  logic                              step,
  input  logic [NWORDS-1:0][sha5_pkg::WORD_W-1:0] block,
  output sha5_pkg::word_t                   w_cur
);
  import sha5_pkg::*;
  logic [NWORDS-1:0][WORD_W-1:0] win_q;
  word_t w_new;

  assign w_new = sml_s1(win_q[NWORDS-2]) + win_q[NWORDS-7]
               + sml_s0(win_q[1]) + win_q[0];
  assign w_cur = win_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (load) begin
      win_q <= block;
    end else if (step) begin
      for (int i = 0; i < NWORDS - 1; i++) win_q[i] <= win_q[i+1];
      win_q[NWORDS-1] <= w_new;
    end
  end

  a_r3_load_step_excl: assert property (@(posedge clk) disable iff (rst)
    !(load && step));
  a_r3_window_shift: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> w_cur == $past(win_q[1]));
endmodule

// File: rtl/sha5_round.sv
module sha5_round (
  input  sha5_pkg::vars_t v_in,
  input  sha5_pkg::word_t k,
  input  sha5_pkg::word_t w,
  output sha5_pkg::vars_t v_out
);
  import sha5_pkg::*;
  word_t t1, t2, ch_v, maj_v;

  assign ch_v  = (v_in[4] & v_in[5]) ^ (~v_in[4] & v_in[6]);
  assign maj_v = (v_in[0] & v_in[1]) ^ (v_in[0] & v_in[2]) ^ (v_in[1] & v_in[2]);
  assign t1    = v_in[7] + big_s1(v_in[4]) + ch_v + k + w;
  assign t2    = big_s0(v_in[0]) + maj_v;

  always_comb begin
    v_out    = v_in;
    v_out[0] = t1 + t2;
    v_out[1] = v_in[0];
    v_out[2] = v_in[1];
    v_out[3] = v_in[2];
    v_out[4] = v_in[3] + t1;
    v_out[5] = v_in[4];
    v_out[6] = v_in[5];
    v_out[7] = v_in[6];
  end
endmodule

// File: rtl/sha5_text_bank.sv
module sha5_text_bank #(
  parameter int NREGS = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_we,
  input  logic [IDX_W-1:0]       host_idx,
  input  logic [31:0]            host_wdata,
  input  logic                   wb_en,
  input  logic [IDX_W:0]         wb_limit,
  input  logic [NREGS-1:0][31:0] wb_data,
  output logic [NREGS-1:0][31:0] text_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      text_q <= '0;
    end else if (wb_en) begin
      for (int r = 0; r < NREGS; r++)
        if (r < int'(wb_limit)) text_q[r] <= wb_data[r];
    end else if (host_we) begin
      text_q[host_idx] <= host_wdata;
    end
  end

  a_r8_wb_host_excl: assert property (@(posedge clk) disable iff (rst)
    !(wb_en && host_we));
endmodule

// File: rtl/sha5_engine.sv
module sha5_engine #(
  parameter int ADDR_W = 6,
  parameter int NREGS  = 32,
  parameter int ROUNDS = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              done
);
  import sha5_pkg::*;
  localparam int IDX_W     = $clog2(NREGS);
  localparam int CNT_W     = $clog2(ROUNDS);
  localparam int NWORDS    = NREGS / 2;
  localparam int REGS_512  = 2 * VAR_CNT;
  localparam int REGS_384  = 2 * (VAR_CNT - 2);
  localparam int A_GO512   = NREGS;
  localparam int A_CT512   = NREGS + 1;
  localparam int A_GO384   = NREGS + 2;
  localparam int A_CT384   = NREGS + 3;
  localparam int A_STATUS  = NREGS + 4;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ADD, S_WB} st_t;
  st_t              state_q;
  vars_t            hash_q, vars_q, vars_nx, iv_w;
  logic [CNT_W-1:0] cnt_q;
  logic             alg384_q;
  word_t            k_cur, w_cur;

  logic [NREGS-1:0][31:0]        text_q, wb_data;
  logic [NWORDS-1:0][WORD_W-1:0] blk_w;
  logic [IDX_W:0]                wb_limit;
  logic is_text, is_cmd, cmd_ok, cmd_start, cmd_384;

  assign is_text   = int'(bus_addr) < NREGS;
  assign is_cmd    = bus_we && int'(bus_addr) >= A_GO512 && int'(bus_addr) <= A_CT384;
  assign cmd_ok    = is_cmd && state_q == S_IDLE;
  assign cmd_start = int'(bus_addr) == A_GO512 || int'(bus_addr) == A_GO384;
  assign cmd_384   = int'(bus_addr) == A_GO384 || int'(bus_addr) == A_CT384;
  assign wb_limit  = alg384_q ? (IDX_W+1)'(REGS_384) : (IDX_W+1)'(REGS_512);

  for (genvar i = 0; i < VAR_CNT; i++) begin : g_iv
    localparam word_t IV_A = frac_root(nth_prime(i), 2);
    localparam word_t IV_B = frac_root(nth_prime(i + VAR_CNT), 2);
    assign iv_w[i] = cmd_384 ? IV_B : IV_A;
  end

  for (genvar j = 0; j < NWORDS; j++) begin : g_blk
    assign blk_w[j] = {text_q[2*j], text_q[2*j+1]};
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_wb
    if (r / 2 < VAR_CNT) begin : g_dig
      assign wb_data[r] = (r % 2 == 0) ? hash_q[r/2][63:32] : hash_q[r/2][31:0];
    end else begin : g_zero
      assign wb_data[r] = '0;
    end
  end

  sha5_text_bank #(.NREGS(NREGS)) bank_i (
    .clk(clk), .rst(rst),
    .host_we(bus_we && is_text && state_q == S_IDLE),
    .host_idx(bus_addr[IDX_W-1:0]), .host_wdata(bus_wdata),
    .wb_en(state_q == S_WB), .wb_limit(wb_limit), .wb_data(wb_data),
    .text_q(text_q));

  sha5_sched #(.NWORDS(NWORDS)) sched_i (
    .clk(clk), .rst(rst), .load(cmd_ok), .step(state_q == S_RUN),
    .block(blk_w), .w_cur(w_cur));

  sha5_krom #(.ROUNDS(ROUNDS)) krom_i (.idx(cnt_q), .k(k_cur));

  sha5_round round_i (.v_in(vars_q), .k(k_cur), .w(w_cur), .v_out(vars_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      hash_q   <= '0;
      vars_q   <= '0;
      cnt_q    <= '0;
      alg384_q <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (cmd_ok) begin
          alg384_q <= cmd_384;
          if (cmd_start) begin
            hash_q <= iv_w;
            vars_q <= iv_w;
          end else begin
            vars_q <= hash_q;
          end
          cnt_q   <= '0;
          busy    <= 1'b1;
          done    <= 1'b0;
          state_q <= S_RUN;
        end
        S_RUN: begin
          vars_q <= vars_nx;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ROUNDS - 1)) state_q <= S_ADD;
        end
        S_ADD: begin
          for (int i = 0; i < VAR_CNT; i++) hash_q[i] <= hash_q[i] + vars_q[i];
          state_q <= S_WB;
        end
        default: begin
          busy    <= 1'b0;
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (is_text) bus_rdata <= text_q[bus_addr[IDX_W-1:0]];
    else if (int'(bus_addr) == A_STATUS) bus_rdata <= {30'd0, done, busy};
    else bus_rdata <= '0;
  end

  a_r7_busy_after_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_ok |=> busy && !done);
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  a_r7_round_range: assert property (@(posedge clk) disable iff (rst)
    state_q == S_RUN |-> int'(cnt_q) < ROUNDS);
  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && state_q == S_RUN) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r8_text_held: assert property (@(posedge clk) disable iff (rst)
    (bus_we && is_text && state_q == S_RUN)
    |=> text_q[$past(bus_addr[IDX_W-1:0])] == $past(text_q[bus_addr[IDX_W-1:0]]));

  for (genvar r = REGS_384; r < NREGS; r++) begin : g_keep
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_WB && r >= int'(wb_limit)) |=> text_q[r] == $past(text_q[r]));
  end
endmodule

// File: tb/sha5_engine_tb_top.sv
`timescale 1ns/1ps
module sha5_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        busy, done;
  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] blk [32];
  logic [63:0] exp_d [8];

  always #10 clk = ~clk;

  sha5_engine dut_i (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(a);
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic load_blk();
    for (int i = 0; i < 32; i++) wr(i, blk[i]);
  endtask

  // issue a command and measure the clocks until done
  task automatic run_cmd(input int a, input string req, output int lat);
    wr(a, 32'h0);
    check({req, " busy after command"}, 64'(busy), 64'd1);
    lat = 0;
    while (!done && lat < 1000) begin
      @(posedge clk); @(negedge clk); lat++;
    end
  endtask

  task automatic check_digest(input int nregs, input string req);
    logic [31:0] d;
    for (int r = 0; r < nregs; r++) begin
      rd(r, d);
      check(req, 64'(d), 64'((r % 2 == 0) ? exp_d[r/2][63:32] : exp_d[r/2][31:0]));
    end
  endtask

  task automatic set_abc();
    for (int i = 0; i < 32; i++) blk[i] = 32'h0;
    blk[0] = 32'h61626380; blk[31] = 32'h00000018;
  endtask

  task automatic set_empty();
    for (int i = 0; i < 32; i++) blk[i] = 32'h0;
    blk[0] = 32'h80000000;
  endtask

  task automatic set_abc512();
    exp_d = '{64'hddaf35a193617aba, 64'hcc417349ae204131, 64'h12e6fa4e89a97ea2,
              64'h0a9eeee64b55d39a, 64'h2192992a274fc1a8, 64'h36ba3c23a3feebbd,
              64'h454d4423643ce80e, 64'h2a9ac94fa54ca49f};
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 busy at reset", 64'(busy), 64'd0);
    check("R1 done at reset", 64'(done), 64'd0);
    rd(5, d);  check("R1 text reg zero", 64'(d), 64'd0);
    rd(31, d); check("R1 text reg zero", 64'(d), 64'd0);
    rd(36, d); check("R9 idle status", 64'(d), 64'd0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(7, 32'hA5A5_0F0F);
    rd(7, d); check("R2 readback", 64'(d), 64'hA5A50F0F);
  endtask

  task automatic t_abc512();
    int lat; logic [31:0] d;
    set_abc(); load_blk(); set_abc512();
    run_cmd(32, "R7", lat);
    check("R7 latency", 64'(lat), 64'd82);
    check("R7 busy low at done", 64'(busy), 64'd0);
    rd(36, d); check("R9 done status", 64'(d), 64'd2);
    check_digest(16, "R3 R4 sha512 abc");
    for (int r = 16; r < 31; r++) begin
      rd(r, d); check("R4 upper regs kept", 64'(d), 64'd0);
    end
    rd(31, d); check("R4 upper regs kept", 64'(d), 64'h18);
  endtask

  task automatic t_abc384();
    int lat; logic [31:0] d;
    set_abc(); load_blk();
    exp_d = '{64'hcb00753f45a35e8b, 64'hb5a03d699ac65007, 64'h272c32ab0eded163,
              64'h1a8b605a43ff5bed, 64'h8086072ba1e7cc23, 64'h58baeca134c825a7,
              64'h0, 64'h0};
    run_cmd(34, "R7", lat);
    check("R7 latency 384", 64'(lat), 64'd82);
    check_digest(12, "R3 R5 sha384 abc");
    for (int r = 12; r < 31; r++) begin
      rd(r, d); check("R5 regs 12-31 kept", 64'(d), 64'd0);
    end
    rd(31, d); check("R5 last reg kept", 64'(d), 64'h18);
  endtask

  task automatic t_empty();
    int lat;
    set_empty(); load_blk();
    exp_d = '{64'hcf83e1357eefb8bd, 64'hf1542850d66d8007, 64'hd620e4050b5715dc,
              64'h83f4a921d36ce9ce, 64'h47d0d13c5d85f2b0, 64'hff8318d2877eec2f,
              64'h63b931bd47417a81, 64'ha538327af927da3e};
    run_cmd(32, "R3", lat);
    check_digest(16, "R3 sha512 empty");
    set_empty(); load_blk();
    exp_d = '{64'h38b060a751ac9638, 64'h4cd9327eb1b1e36a, 64'h21fdb71114be0743,
              64'h4c0cc7bf63f6e1da, 64'h274edebfe76f65fb, 64'hd51ad2f14898b95b,
              64'h0, 64'h0};
    run_cmd(34, "R3", lat);
    check_digest(12, "R3 sha384 empty");
  endtask

  task automatic t_chain();
    int lat;
    string msg;
    logic [7:0] by [128];
    msg = {"abcdefghbcdefghicdefghijdefghijkefghijklfghijklmghijklmn",
           "hijklmnoijklmnopjklmnopqklmnopqrlmnopqrsmnopqrstnopqrstu"};
    for (int i = 0; i < 128; i++) by[i] = (i < 112) ? msg[i] : 8'h00;
    by[112] = 8'h80;
    for (int i = 0; i < 32; i++) blk[i] = {by[4*i], by[4*i+1], by[4*i+2], by[4*i+3]};
    load_blk();
    run_cmd(32, "R6", lat);
    for (int i = 0; i < 32; i++) blk[i] = 32'h0;
    blk[31] = 32'h00000380;
    load_blk();
    exp_d = '{64'h8e959b75dae313da, 64'h8cf4f72814fc143f, 64'h8f7779c6eb9f7fa1,
              64'h7299aeadb6889018, 64'h501d289e4900f7e4, 64'h331b99dec4b5433a,
              64'hc7d329eeb6dd2654, 64'h5e96e55b874be909};
    run_cmd(33, "R6", lat);
    check("R6 continue latency", 64'(lat), 64'd82);
    check_digest(16, "R6 two-block chain");
  endtask

  task automatic t_busy_ignore();
    int lat; logic [31:0] d;
    set_abc(); load_blk(); set_abc512();
    wr(32, 32'h0);
    lat = 1;
    wr(0, 32'hDEADBEEF);  lat += 2;
    wr(20, 32'h12345678); lat += 2;
    wr(34, 32'h0);        lat += 2;
    rd(36, d);            lat += 1;
    check("R9 busy status", 64'(d), 64'd1);
    while (!done && lat < 1000) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check("R8 late command not restarting", 64'(lat), 64'd82);
    check_digest(16, "R8 digest unaffected");
    rd(20, d); check("R8 write while busy ignored", 64'(d), 64'd0);
    wr(33, 32'h0);
    check("R7 done cleared by command", 64'(done), 64'd0);
    while (!done) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_readback();
    t_abc512();
    t_abc384();
    t_empty();
    t_chain();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule